// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block receives a stereo digital audio stream in slave mode. Three lines come in: a bit clock, a word-select line and a single data line. Left and right words share the data line one after the other, and the word-select level says which channel is on the line. The block turns these words into parallel 20-bit two's-complement samples. Each left/right pair is handed to the system clock domain with a one-cycle valid strobe.

A two-bit format input chooses the framing. In the standard I2S framing the MSB comes one bit after the word-select change. In the three right-justified framings the word is the last 16, 18 or 20 bits before the change. Both framings run through one shift engine, and every word is left-aligned into the 20-bit output. The bit clock is supplied from outside at 48 or 64 times the sample rate. All line sampling happens on its rising edge. The finished pair crosses into the system domain through a toggle handshake.

Top module: `aud_serial_rx`

## Requirements
- R1: While rst_ni is low, and after its release until the first pair is delivered, valid_o is 0 and left_o and right_o are 0.
- R2: With fmt_i = 2'b00 (I2S), the word MSB is the data bit sampled one bit-clock rising edge after the edge at which a new word-select level is first sampled. The word ends with the bit sampled at the edge where the next word-select change is first seen. Words of up to 20 bits are accepted.
- R3: In I2S mode, bits after the twentieth bit of a word are ignored; the output holds the word's first 20 bits.
- R4: With fmt_i = 2'b01, 2'b10 or 2'b11 the word length N is 16, 18 or 20. The word is the last N data bits sampled before the edge at which a word-select change is first seen. Earlier bits of the slot are ignored.
- R5: Every output sample is 20 bits wide. A word shorter than 20 bits fills the top bits, MSB at bit 19, and the remaining low bits are 0.
- R6: Word select low marks the left channel and high the right channel. A pair is delivered only after a left word has been captured followed by a right word. A right word with no left word pending delivers nothing.
- R7: valid_o is high for exactly one system-clock cycle per delivered pair. left_o and right_o change only in that cycle and hold their values otherwise.
- R8: Operation is correct with 24-bit and 32-bit channel slots (bit clock at 48 or 64 times the sample rate).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, output domain |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| bclk_i | input | 1 | Serial bit clock, inputs sampled on its rising edge |
| ws_i | input | 1 | Word select, low = left, high = right |
| sd_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Framing: 00 I2S, 01/10/11 right-justified 16/18/20 bits |
| valid_o | output | 1 | One-cycle strobe, new pair on left_o/right_o |
| left_o | output | 20 | Left sample, two's complement, left-aligned |
| right_o | output | 20 | Right sample, two's complement, left-aligned |

## Verification
The assertions assume that fmt_i changes only while rst_ni is low. They also assume that word select changes at most once per channel slot and that a full frame spans far more system-clock cycles than the synchronizer delay, so a single valid pulse never collides with the next one. The stimulus holds the format under reset for each block and uses 24- or 32-bit slots with a bit clock several times slower than the system clock. Every stream opens with a right-channel slot, so the first word seen after reset is one that R6 discards.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  localparam int unsigned SAMPLE_W  = 20;
  localparam int unsigned RJ16_LEN  = 16;
  localparam int unsigned RJ18_LEN  = 18;
  localparam int unsigned RJ20_LEN  = 20;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'b00,
    FMT_RJ16 = 2'b01,
    FMT_RJ18 = 2'b10,
    FMT_RJ20 = 2'b11
  } fmt_e;
endpackage

// File: rtl/aud_rx_frame.sv
module aud_rx_frame
  import aud_rx_pkg::*;
#(
  parameter int unsigned W = SAMPLE_W
) (
  input  logic         bclk_i,
  input  logic         rst_ni,
  input  logic         ws_i,
  input  logic         sd_i,
  input  logic [1:0]   fmt_i,
  output logic         stb_o,
  output logic         chan_o,
  output logic [W-1:0] word_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic          ws_d, armed;
  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;
  logic          chg, is_i2s;
  logic [CW-1:0] n_bits, rj_len;
  logic [W-1:0]  full, i2s_word, rj_mask, rj_word;

  assign chg    = armed && (ws_i != ws_d);
  assign is_i2s = (fmt_e'(fmt_i) == FMT_I2S);

  always_comb begin
    // I2S: the bit seen on the change edge still belongs to the ending word
    if (cnt < CW'(W)) begin
      full   = {sh[W-2:0], sd_i};
      n_bits = cnt + CW'(1);
    end else begin
      full   = sh;
      n_bits = CW'(W);
    end
    i2s_word = full << (CW'(W) - n_bits);

    unique case (fmt_e'(fmt_i))
      FMT_RJ16: rj_len = CW'(RJ16_LEN);
      FMT_RJ18: rj_len = CW'(RJ18_LEN);
      default:  rj_len = CW'(RJ20_LEN);
    endcase
    rj_mask = {W{1'b1}} >> (CW'(W) - rj_len);
    rj_word = (sh & rj_mask) << (CW'(W) - rj_len);
  end

  always_ff @(posedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_d   <= 1'b0;
      armed  <= 1'b0;
      sh     <= '0;
      cnt    <= '0;
      stb_o  <= 1'b0;
      chan_o <= 1'b0;
      word_o <= '0;
    end else begin
      armed <= 1'b1;
      ws_d  <= ws_i;
      stb_o <= chg;
      if (chg) begin
        word_o <= is_i2s ? i2s_word : rj_word;
        chan_o <= ws_d;
      end
      if (is_i2s) begin
        if (chg) begin
          sh  <= '0;
          cnt <= '0;
        end else if (cnt < CW'(W)) begin
          sh  <= {sh[W-2:0], sd_i};
          cnt <= cnt + CW'(1);
        end
      end else begin
        sh <= {sh[W-2:0], sd_i};
      end
    end
  end
endmodule

// File: rtl/aud_rx_pair.sv
module aud_rx_pair #(
  parameter int unsigned W = 20
) (
  input  logic         bclk_i,
  input  logic         rst_ni,
  input  logic         stb_i,
  input  logic         chan_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         tog_o
);
  logic [W-1:0] left_hold;
  logic         have_left;

  always_ff @(posedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_hold <= '0;
      have_left <= 1'b0;
      left_o    <= '0;
      right_o   <= '0;
      tog_o     <= 1'b0;
    end else if (stb_i) begin
      if (!chan_i) begin
        left_hold <= word_i;
        have_left <= 1'b1;
      end else if (have_left) begin
        left_o    <= left_hold;
        right_o   <= word_i;
        tog_o     <= ~tog_o;
        have_left <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int unsigned W      = 20,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tog_i,
  input  logic [W-1:0] left_i,
  input  logic [W-1:0] right_i,
  output logic         valid_o,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o
);
  logic [STAGES-1:0] sync_q;
  logic              seen_q;
  logic              fresh;

  assign fresh = sync_q[STAGES-1] ^ seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      seen_q  <= 1'b0;
      valid_o <= 1'b0;
      left_o  <= '0;
      right_o <= '0;
    end else begin
      sync_q  <= {sync_q[STAGES-2:0], tog_i};
      seen_q  <= sync_q[STAGES-1];
      valid_o <= fresh;
      // pair registers are quiet for a whole frame after the toggle
      if (fresh) begin
        left_o  <= left_i;
        right_o <= right_i;
      end
    end
  end
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int unsigned SAMPLE_BITS = SAMPLE_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   bclk_i,
  input  logic                   ws_i,
  input  logic                   sd_i,
  input  logic [1:0]             fmt_i,
  output logic                   valid_o,
  output logic [SAMPLE_BITS-1:0] left_o,
  output logic [SAMPLE_BITS-1:0] right_o
);
  logic                   f_stb, f_chan, p_tog;
  logic [SAMPLE_BITS-1:0] f_word, p_left, p_right;

  aud_rx_frame #(.W(SAMPLE_BITS)) u_frame (
    .bclk_i (bclk_i),
    .rst_ni (rst_ni),
    .ws_i   (ws_i),
    .sd_i   (sd_i),
    .fmt_i  (fmt_i),
    .stb_o  (f_stb),
    .chan_o (f_chan),
    .word_o (f_word)
  );

  aud_rx_pair #(.W(SAMPLE_BITS)) u_pair (
    .bclk_i  (bclk_i),
    .rst_ni  (rst_ni),
    .stb_i   (f_stb),
    .chan_i  (f_chan),
    .word_i  (f_word),
    .left_o  (p_left),
    .right_o (p_right),
    .tog_o   (p_tog)
  );

  aud_rx_sync #(.W(SAMPLE_BITS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tog_i   (p_tog),
    .left_i  (p_left),
    .right_i (p_right),
    .valid_o (valid_o),
    .left_o  (left_o),
    .right_o (right_o)
  );
endmodule

// File: rtl/aud_rx_chk.sv
module aud_rx_chk
  import aud_rx_pkg::*;
#(
  parameter int unsigned W = SAMPLE_W
) (
  input logic         clk_i,
  input logic         bclk_i,
  input logic         rst_ni,
  input logic [1:0]   fmt_i,
  input logic         valid_o,
  input logic [W-1:0] left_o,
  input logic [W-1:0] right_o,
  input logic         stb,
  input logic         chan,
  input logic [W-1:0] word,
  input logic         tog
);
  a_r7_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  // R6: a pair only leaves after a right word was captured
  a_r6_pair_after_right: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    (tog != $past(tog)) |-> $past(stb && chan));

  a_r5_rj16_pad: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    (stb && fmt_e'(fmt_i) == FMT_RJ16) |-> (word[W-RJ16_LEN-1:0] == '0));

  a_r5_rj18_pad: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    (stb && fmt_e'(fmt_i) == FMT_RJ18) |-> (word[W-RJ18_LEN-1:0] == '0));
endmodule

bind aud_serial_rx aud_rx_chk #(.W(SAMPLE_BITS)) u_chk (
  .clk_i   (clk_i),
  .bclk_i  (bclk_i),
  .rst_ni  (rst_ni),
  .fmt_i   (fmt_i),
  .valid_o (valid_o),
  .left_o  (left_o),
  .right_o (right_o),
  .stb     (f_stb),
  .chan    (f_chan),
  .word    (f_word),
  .tog     (p_tog)
);

// File: tb/aud_serial_rx_bench.sv
module aud_serial_rx_bench;
  localparam int CLK_PERIOD  = 10;
  localparam int BCLK_HALF   = 23;
  localparam int MAX_BITS    = 2048;
  localparam int MAX_FRAMES  = 16;
  localparam int WATCHDOG    = 200000;

  logic        clk = 1'b0, bclk = 1'b0, rst_n = 1'b0;
  logic        ws = 1'b1, sd = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic        valid;
  logic [19:0] left, right;

  bit          ws_s [MAX_BITS];
  bit          sd_s [MAX_BITS];
  logic [19:0] exp_l [MAX_FRAMES];
  logic [19:0] exp_r [MAX_FRAMES];
  int          n_exp, n_got;
  int          n_chk, n_fail;
  bit          done;
  string       cur_tag;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(BCLK_HALF) bclk = ~bclk;

  aud_serial_rx u_aud_serial_rx (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .bclk_i  (bclk),
    .ws_i    (ws),
    .sd_i    (sd),
    .fmt_i   (fmt),
    .valid_o (valid),
    .left_o  (left),
    .right_o (right)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected 20-bit sample of a len-bit word, per R2/R3/R4/R5
  function automatic logic [19:0] expect_word(input logic [1:0] f, input logic [31:0] w, input int len);
    logic [31:0] v;
    if (f == 2'b00 && len > 20) v = w >> (len - 20);
    else                        v = w << (20 - len);
    return v[19:0];
  endfunction

  function automatic int rj_len(input logic [1:0] f);
    return (f == 2'b01) ? 16 : (f == 2'b10) ? 18 : 20;
  endfunction

  // monitor: pairs in order; outputs held between pulses (R7)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (valid) begin
        if (n_got < n_exp) begin
          check({cur_tag, " left"},  {12'd0, left},  {12'd0, exp_l[n_got]});
          check({cur_tag, " right"}, {12'd0, right}, {12'd0, exp_r[n_got]});
        end else begin
          check("R6 unexpected pair", 32'(n_got), 32'(n_exp - 1));
        end
        n_got++;
      end else if (n_got > 0 && n_got <= n_exp) begin
        check("R7 hold", {12'd0, left}, {12'd0, exp_l[n_got-1]});
      end
    end
  end

  task automatic run_block(input logic [1:0] f, input int slot, input int nfr,
                           input int i2s_len, input string tag);
    int len, t, total;
    logic [31:0] mask, w;
    len   = (f == 2'b00) ? i2s_len : rj_len(f);
    mask  = 32'((64'd1 << len) - 64'd1);
    total = slot * (2 * nfr + 2);
    rst_n = 1'b0;
    fmt   = f;
    ws    = 1'b1;
    sd    = 1'b0;
    n_got = 0;
    n_exp = nfr;
    cur_tag = tag;
    for (int i = 0; i < MAX_BITS; i++) begin
      ws_s[i] = 1'b0;
      // I2S pads with zeros after the LSB; right-justified slots carry junk
      sd_s[i] = (f == 2'b00) ? 1'b0 : 1'($urandom);
    end
    for (int i = 0; i < slot; i++) ws_s[i] = 1'b1;
    t = slot;
    for (int fr = 0; fr < nfr; fr++) begin
      for (int c = 0; c < 2; c++) begin
        case (fr * 2 + c)
          0:       w = mask;
          1:       w = 32'd1 << (len - 1);
          2:       w = mask >> 1;
          3:       w = 32'd0;
          default: w = $urandom & mask;
        endcase
        for (int p = 0; p < slot; p++) ws_s[t + p] = 1'(c);
        for (int i = 0; i < len; i++) begin
          if (f == 2'b00) sd_s[t + 1 + i]          = w[len - 1 - i];
          else            sd_s[t + slot - len + i] = w[len - 1 - i];
        end
        if (c == 0) exp_l[fr] = expect_word(f, w, len);
        else        exp_r[fr] = expect_word(f, w, len);
        t += slot;
      end
    end
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'd0, valid}, 32'd0);
    check("R1 reset left",  {12'd0, left},  32'd0);
    check("R1 reset right", {12'd0, right}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < total; i++) begin
      @(negedge bclk);
      ws = ws_s[i];
      sd = sd_s[i];
    end
    repeat (4) @(negedge bclk);
    repeat (10) @(negedge clk);
    check({tag, " R6 R7 pair count"}, 32'(n_got), 32'(n_exp));
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1548));
    n_chk = 0;
    n_fail = 0;
    done = 1'b0;
    run_block(2'b00, 32, 6, 16, "R2 R5 i2s16");
    run_block(2'b00, 32, 6, 20, "R2 i2s20");
    run_block(2'b00, 32, 6, 24, "R3 i2s24");
    run_block(2'b00, 32, 5, 32, "R3 i2s32");
    run_block(2'b00, 24, 6, 18, "R2 R8 i2s18 slot24");
    run_block(2'b01, 32, 6, 0,  "R4 R5 rj16");
    run_block(2'b10, 32, 6, 0,  "R4 R5 rj18");
    run_block(2'b11, 32, 6, 0,  "R4 rj20");
    run_block(2'b11, 24, 6, 0,  "R4 R8 rj20 slot24");
    run_block(2'b01, 24, 6, 0,  "R4 R8 rj16 slot24");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule